// File: doc/BRIEF.md
# Power Mode Toggle Controller

This block moves a chip between its two active power modes on a command from the host. A start pulse samples the current mode code. The block picks the target mode: mode 0 goes to mode 1, and mode 1 or sleep goes back to mode 0. It then issues three register writes on consecutive cycles. The first write loads the gate register of the target mode's pair. The second loads that pair's clock register. The third loads the mode control register with the new mode.

After the third write, the block watches a sleep-status input. It raises its done pulse only once that input reads inactive. An invalid mode code ends the command at once, with no write.

A register bank receives the single-cycle write strobe with its address and data. The bank itself and the clock generation are outside this block.

Top module: `pwr_mode_toggle`

## Requirements
- R1: With mode code 2'b00 sampled at start, the gate write goes to GATE1_ADDR and the clock write goes to CLK1_ADDR, and the control write carries mode 2'b01.
- R2: With mode code 2'b01 (mode 1) or 2'b10 (sleep) sampled at start, the gate write goes to GATE0_ADDR and the clock write goes to CLK0_ADDR, and the control write carries mode 2'b00.
- R3: With mode code 2'b11 sampled at start, no write is issued and done pulses in the next cycle.
- R4: Every gate write carries the data value GATE_VALUE (default 0x0002000F).
- R5: The clock write carries the clock-configuration word sampled in the start cycle. Later changes to that input have no effect on it.
- R6: The writes occupy three consecutive cycles, beginning in the cycle after start, in this order: gate, clock, control (CTRL_ADDR).
- R7: The control write data holds the new mode in bits [1:0], and all other bits are zero.
- R8: Done is withheld while sleep_active is high. Done rises in the cycle after the first clock edge at which the block is waiting and sleep_active is sampled low. The earliest such edge is two cycles after the control write.
- R9: A start pulse that arrives while a command is in progress, up to and including the edge at which done is decided, is ignored.
- R10: During and just after reset, wr_en and done are low.
- R11: Done lasts exactly one cycle, and each write strobe lasts one cycle per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Toggle command pulse |
| cur_mode | input | 2 | Current mode code: 00 mode 0, 01 mode 1, 10 sleep, 11 invalid |
| clk_cfg | input | DATA_W | Clock-configuration word for the target mode |
| sleep_active | input | 1 | High while the chip still reports sleep as active |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| done | output | 1 | Command finished pulse |

## Verification
The hardest situation to reach is a second start that lands while the block is busy. This matters most in the waiting phase, where sleep_active is held high for several cycles and the extra start meets a command that has already stopped writing. The bench holds sleep_active high after a toggle out of sleep and fires a start with a different mode code during that wait. It then releases sleep_active. It also places a start on the exact edge at which done is decided and another on the edge just after. The reference model predicts every cycle through all of this.

// File: rtl/pwr_mode_toggle.sv
module pwr_mode_toggle #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h3C,
  parameter logic [ADDR_W-1:0] GATE0_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] CLK0_ADDR  = 8'h44,
  parameter logic [ADDR_W-1:0] GATE1_ADDR = 8'h48,
  parameter logic [ADDR_W-1:0] CLK1_ADDR  = 8'h4C,
  parameter logic [DATA_W-1:0] GATE_VALUE = 32'h0002_000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cur_mode,
  input  logic [DATA_W-1:0] clk_cfg,
  input  logic              sleep_active,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  typedef enum logic [2:0] {S_IDLE, S_GATE, S_CLK, S_CTRL, S_WAIT} st_t;

  st_t               st;
  logic              to_m1;
  logic [DATA_W-1:0] cfg_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      to_m1  <= 1'b0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (cur_mode == 2'b11) begin
            done_q <= 1'b1;
          end else begin
            to_m1 <= (cur_mode == 2'b00);
            cfg_q <= clk_cfg;
            st    <= S_GATE;
          end
        end
        S_GATE: st <= S_CLK;
        S_CLK:  st <= S_CTRL;
        S_CTRL: st <= S_WAIT;
        S_WAIT: if (!sleep_active) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_en = (st == S_GATE) || (st == S_CLK) || (st == S_CTRL);
  assign done  = done_q;

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    case (st)
      S_GATE: begin
        wr_addr = to_m1 ? GATE1_ADDR : GATE0_ADDR;
        wr_data = GATE_VALUE;
      end
      S_CLK: begin
        wr_addr = to_m1 ? CLK1_ADDR : CLK0_ADDR;
        wr_data = cfg_q;
      end
      S_CTRL: begin
        wr_addr = CTRL_ADDR;
        wr_data = {{(DATA_W-2){1'b0}}, 1'b0, to_m1};
      end
      default: ;
    endcase
  end
endmodule

module pwr_mode_toggle_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h3C,
  parameter logic [ADDR_W-1:0] GATE0_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] CLK0_ADDR  = 8'h44,
  parameter logic [ADDR_W-1:0] GATE1_ADDR = 8'h48,
  parameter logic [ADDR_W-1:0] CLK1_ADDR  = 8'h4C,
  parameter logic [DATA_W-1:0] GATE_VALUE = 32'h0002_000F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done
);
  assert_gate_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == GATE0_ADDR || wr_addr == GATE1_ADDR)) |-> (wr_data == GATE_VALUE));

  assert_clk_follows_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == GATE0_ADDR || wr_addr == GATE1_ADDR)) |=>
      (wr_en && wr_addr == (($past(wr_addr) == GATE1_ADDR) ? CLK1_ADDR : CLK0_ADDR)));

  assert_ctrl_follows_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == CLK0_ADDR || wr_addr == CLK1_ADDR)) |=> (wr_en && wr_addr == CTRL_ADDR));

  assert_ctrl_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR) |->
      (wr_data[DATA_W-1:2] == '0 && wr_data[1] == 1'b0 &&
       wr_data[0] == ($past(wr_addr) == CLK1_ADDR)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_done_after_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR) |=> !done);

  assert_no_done_with_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done);
endmodule

bind pwr_mode_toggle pwr_mode_toggle_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .GATE0_ADDR(GATE0_ADDR), .CLK0_ADDR(CLK0_ADDR),
  .GATE1_ADDR(GATE1_ADDR), .CLK1_ADDR(CLK1_ADDR), .GATE_VALUE(GATE_VALUE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .done(done)
);

// File: tb/pwr_mode_toggle_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_toggle_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cur_mode = 2'b00;
  logic [31:0] clk_cfg = 32'h0;
  logic        sleep_active = 1'b0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        done;

  always #4 clk = ~clk;

  pwr_mode_toggle dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_mode(cur_mode),
    .clk_cfg(clk_cfg), .sleep_active(sleep_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string req = "R10";

  // reference model
  int q_addr[$];
  int q_data[$];
  bit busy = 0, polling = 0;
  bit e_wr = 0, e_done = 0;
  int e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    e_wr = 0; e_done = 0; e_addr = 0; e_data = 0;
    if (!rst_n) begin
      q_addr.delete(); q_data.delete(); busy = 0; polling = 0;
    end else begin
      if (!busy && start) begin
        if (cur_mode == 2'b11) e_done = 1;
        else begin
          busy = 1;
          q_addr.push_back(cur_mode == 2'b00 ? 'h48 : 'h40);
          q_data.push_back('h2000F);
          q_addr.push_back(cur_mode == 2'b00 ? 'h4C : 'h44);
          q_data.push_back(int'(clk_cfg));
          q_addr.push_back('h3C);
          q_data.push_back(cur_mode == 2'b00 ? 1 : 0);
        end
      end else if (busy && polling) begin
        if (!sleep_active) begin e_done = 1; busy = 0; polling = 0; end
      end else if (busy && q_addr.size() == 0) begin
        polling = 1;
      end
      if (q_addr.size() > 0) begin
        e_wr = 1; e_addr = q_addr.pop_front(); e_data = q_data.pop_front();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (wr_en !== e_wr || done !== e_done ||
          (e_wr && (wr_addr !== 8'(e_addr) || wr_data !== 32'(e_data)))) begin
        n_bad++;
        $display("FAIL %s: wr_en=%0b addr=%h data=%h done=%0b expected wr_en=%0b addr=%h data=%h done=%0b",
                 req, wr_en, wr_addr, wr_data, done, e_wr, 8'(e_addr), 32'(e_data), e_done);
      end
    end
  end

  task automatic pulse(input logic [1:0] m, input logic [31:0] cfg);
    @(negedge clk);
    start = 1'b1; cur_mode = m; clk_cfg = cfg;
    @(negedge clk);
    start = 1'b0; clk_cfg = ~cfg; cur_mode = 2'b11;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (wr_en !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: wr_en=%0b done=%0b expected 0 0", wr_en, done);
    end
    rst_n = 1'b1;
    idle(2);
    req = "R1"; pulse(2'b00, 32'hA5A5_0001); idle(8);
    req = "R2"; pulse(2'b01, 32'h0000_1234); idle(8);
    req = "R4"; pulse(2'b00, 32'hFFFF_FFFF); idle(8);
    req = "R3"; pulse(2'b11, 32'h1111_1111); idle(4);
    // R3 then immediate valid start
    @(negedge clk); start = 1'b1; cur_mode = 2'b11;
    @(negedge clk); cur_mode = 2'b01; clk_cfg = 32'h55;
    @(negedge clk); start = 1'b0; idle(8);
    // R8: sleep return with held status, R9: start during wait ignored
    req = "R8"; sleep_active = 1'b1;
    pulse(2'b10, 32'hCAFE_0008);
    idle(5);
    req = "R9"; start = 1'b1; cur_mode = 2'b00;
    @(negedge clk); start = 1'b0;
    idle(3);
    req = "R8"; sleep_active = 1'b0;
    // start held across the done decision edge and after it
    req = "R9"; start = 1'b1; cur_mode = 2'b01; clk_cfg = 32'h77;
    @(negedge clk); @(negedge clk); start = 1'b0;
    idle(8);
    // R6, R5, R7, R11: back-to-back commands
    req = "R6"; pulse(2'b00, 32'h0BAD_F00D); idle(6);
    req = "R5"; pulse(2'b10, 32'h1357_9BDF); idle(6);
    req = "R7"; pulse(2'b01, 32'h2468_ACE0); idle(6);
    req = "R11"; pulse(2'b00, 32'h0000_0000); idle(6);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected end before 5000 cycles");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule